// File: doc/BRIEF.md
# Configuration ROM Header Checker

This block watches a byte stream that carries a device configuration ROM image, first byte first, and decides whether the image header can be trusted. While the bytes go past it collects the 64-bit unique ID and the declared length of the data region. It runs two checksums at once: an 8-bit CRC over the ID and a 32-bit Castagnoli CRC over the data region. The data region includes the revision byte and the length field. At the end it compares both results with the values stored in the image.

A fetch engine feeds one byte per cycle whenever `byte_valid_i` is high, and it may leave idle cycles between bytes. A `start_i` pulse comes before each image. Once the last byte of the data region has been taken, the block raises `result_valid_o`. It then holds the ID, the total image size and four verdict flags until the next `start_i`. Parsing of the entries that follow the header is left to the consumer.

Top module: `rom_hdr_checker`

## Requirements
- R1: After reset, `result_valid_o`, all four flags, `uid_o` and `image_size_o` are zero.
- R2: Image byte 0 holds the stored ID checksum. Bytes 1 to 8 hold the ID in little-endian order (byte 1 goes to `uid_o[7:0]`, byte 8 to `uid_o[63:56]`), and `uid_o` presents it.
- R3: `uid_crc_ok_o` is 1 only if the CRC of bytes 1 to 8 equals byte 0. The CRC is 8 bits wide, starts at 0xFF, and takes each byte MSB first: XOR the byte in, then eight times shift left and XOR 0x07 whenever the bit shifted out was 1.
- R4: The data length L is the 16-bit little-endian field at bytes 14 (low) and 15 (high). `image_size_o` equals L + 13.
- R5: `data_crc_ok_o` is 1 only if the CRC-32C of the L bytes starting at byte 13 equals the stored value in bytes 9 to 12 (little-endian, byte 9 least significant). The CRC uses the reflected polynomial 0x82F63B78, starts at all ones, takes bits LSB first and is inverted at the end.
- R6: If byte 13 (revision) is greater than 1, `rev_warn_o` is 1. The revision has no effect on the other flags.
- R7: If L + 13 < 22, the result is presented one cycle after byte 15 is taken, with `size_ok_o` = 0 and `data_crc_ok_o` = 0. Otherwise `size_ok_o` = 1.
- R8: Bytes advance only on cycles with `byte_valid_i` high. `result_valid_o` rises in the cycle after byte index L + 12 is taken.
- R9: While `result_valid_o` is high, further bytes are ignored and every output holds its value.
- R10: `start_i` clears all outputs, and the next byte taken after it is byte 0. A byte presented in the same cycle as `start_i` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new image |
| byte_valid_i | input | 1 | `byte_i` carries the next image byte |
| byte_i | input | 8 | Image byte |
| result_valid_o | output | 1 | Verdict outputs are valid |
| size_ok_o | output | 1 | Image is not smaller than the fixed header |
| uid_crc_ok_o | output | 1 | ID checksum matches |
| data_crc_ok_o | output | 1 | Data-region checksum matches |
| rev_warn_o | output | 1 | Revision byte above 1 |
| uid_o | output | 64 | Captured unique ID |
| image_size_o | output | 17 | Total image size, L + 13 |

## Verification
The bench builds images with a bench-side model of both CRCs and feeds them with random idle gaps. A design that advanced on idle cycles would then misalign every field and fail both checksums. Images are corrupted in byte 0 alone or in one payload byte alone. A design that mixed up the two checksum regions, or fed the length bytes to the wrong CRC, would flag the wrong one. Length 9 (exactly the header size) and lengths 8 and 0 are covered: an off-by-one in the size limit would accept or reject the wrong image, and a missing early exit would hang waiting for bytes that never come. Extra bytes after the verdict, and a byte sent together with `start_i`, expose a design that keeps counting or that takes a garbage byte as byte 0.

// File: rtl/rhc_pkg.sv
package rhc_pkg;

    localparam int unsigned BYTE_W         = 8;
    localparam int unsigned UID_BYTES      = 8;
    localparam int unsigned REF32_BYTES    = 4;
    localparam int unsigned POS_CRC8_REF   = 0;
    localparam int unsigned POS_UID_FIRST  = 1;
    localparam int unsigned POS_CRC32_REF  = 9;
    localparam int unsigned POS_REV        = 13;
    localparam int unsigned POS_LEN        = 14;
    localparam int unsigned DATA_START     = 13;

    localparam logic [7:0]  CRC8_POLY      = 8'h07;
    localparam logic [7:0]  CRC8_SEED      = 8'hFF;
    localparam logic [31:0] CRC32C_POLY_R  = 32'h82F63B78;
    localparam logic [31:0] CRC32C_SEED    = 32'hFFFF_FFFF;
    localparam logic [7:0]  REV_MAX_KNOWN  = 8'd1;

    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_DONE = 1'b1
    } phase_e;

endpackage

// File: rtl/rhc_crc_unit.sv
module rhc_crc_unit #(
    parameter int unsigned       CRC_W   = 8,
    parameter logic [CRC_W-1:0]  POLY    = '1,
    parameter logic [CRC_W-1:0]  SEED    = '1,
    parameter bit                REFLECT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             en_i,
    input  logic [7:0]       data_i,
    output logic [CRC_W-1:0] crc_o,
    output logic [CRC_W-1:0] crc_next_o
);

    logic [CRC_W-1:0] crc_d, crc_q;
    logic [CRC_W-1:0] stepped;

    generate
        if (REFLECT) begin : g_lsb_first
            always_comb begin
                logic [CRC_W-1:0] c;
                c = crc_q ^ CRC_W'(data_i);
                for (int b = 0; b < 8; b++) begin
                    c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
                end
                stepped = c;
            end
        end else begin : g_msb_first
            always_comb begin
                logic [CRC_W-1:0] c;
                c = crc_q ^ (CRC_W'(data_i) << (CRC_W - 8));
                for (int b = 0; b < 8; b++) begin
                    c = c[CRC_W-1] ? ((c << 1) ^ POLY) : (c << 1);
                end
                stepped = c;
            end
        end
    endgenerate

    always_comb begin
        crc_d = crc_q;
        if (init_i) begin
            crc_d = SEED;
        end else if (en_i) begin
            crc_d = stepped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= SEED;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc_o      = crc_q;
    assign crc_next_o = stepped;

    // Accumulator moves only on an enabled byte (R8, R5)
    assert_crc_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !init_i) |=> $stable(crc_o));

    // Restart reloads the seed (R10)
    assert_crc_reseed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (crc_o == SEED));

endmodule

// File: rtl/rhc_field_capture.sv
module rhc_field_capture
    import rhc_pkg::*;
#(
    parameter int unsigned CNT_W = 17,
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             take_i,
    input  logic [CNT_W-1:0] idx_i,
    input  logic [7:0]       byte_i,
    output logic [63:0]      uid_o,
    output logic [7:0]       crc8_ref_o,
    output logic [31:0]      crc32_ref_o,
    output logic [7:0]       rev_o,
    output logic [LEN_W-1:0] len_next_o
);

    localparam int unsigned LEN_BYTES = LEN_W / BYTE_W;

    typedef struct packed {
        logic [63:0]      uid;
        logic [7:0]       crc8_ref;
        logic [31:0]      crc32_ref;
        logic [7:0]       rev;
        logic [LEN_W-1:0] len;
    } fields_t;

    fields_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (clear_i) begin
            f_d = '0;
        end else if (take_i) begin
            if (idx_i == CNT_W'(POS_CRC8_REF)) begin
                f_d.crc8_ref = byte_i;
            end
            for (int k = 0; k < UID_BYTES; k++) begin
                if (idx_i == CNT_W'(POS_UID_FIRST + k)) begin
                    f_d.uid[8*k +: 8] = byte_i;
                end
            end
            for (int k = 0; k < REF32_BYTES; k++) begin
                if (idx_i == CNT_W'(POS_CRC32_REF + k)) begin
                    f_d.crc32_ref[8*k +: 8] = byte_i;
                end
            end
            if (idx_i == CNT_W'(POS_REV)) begin
                f_d.rev = byte_i;
            end
            for (int k = 0; k < LEN_BYTES; k++) begin
                if (idx_i == CNT_W'(POS_LEN + k)) begin
                    f_d.len[8*k +: 8] = byte_i;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign uid_o       = f_q.uid;
    assign crc8_ref_o  = f_q.crc8_ref;
    assign crc32_ref_o = f_q.crc32_ref;
    assign rev_o       = f_q.rev;
    assign len_next_o  = f_d.len;

    // ID bytes only change while their own slots are being taken (R2)
    assert_uid_settled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && take_i && idx_i > CNT_W'(POS_UID_FIRST + UID_BYTES - 1)) |=> $stable(uid_o));

endmodule

// File: rtl/rom_hdr_checker.sv
module rom_hdr_checker
    import rhc_pkg::*;
#(
    parameter int unsigned LEN_W     = 16,
    parameter int unsigned HDR_BYTES = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             byte_valid_i,
    input  logic [7:0]       byte_i,
    output logic             result_valid_o,
    output logic             size_ok_o,
    output logic             uid_crc_ok_o,
    output logic             data_crc_ok_o,
    output logic             rev_warn_o,
    output logic [63:0]      uid_o,
    output logic [LEN_W:0]   image_size_o
);

    localparam int unsigned SIZE_W   = LEN_W + 1;
    localparam int unsigned CNT_W    = LEN_W + 1;
    localparam int unsigned UID_LAST = POS_UID_FIRST + UID_BYTES - 1;
    localparam int unsigned LEN_LAST = POS_LEN + LEN_W / BYTE_W - 1;

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  idx;
        logic              uid_match;
        logic [SIZE_W-1:0] size;
        logic              valid;
        logic              size_ok;
        logic              uid_ok;
        logic              data_ok;
        logic              warn;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              take;
    logic [7:0]        crc8_now, crc8_next, crc8_ref;
    logic [31:0]       crc32_now, crc32_next, crc32_ref;
    logic [7:0]        rev;
    logic [LEN_W-1:0]  len_next;
    logic              crc8_en, crc32_en;

    assign take     = byte_valid_i && !start_i && (c_q.phase == PH_RUN);
    assign crc8_en  = take && (c_q.idx >= CNT_W'(POS_UID_FIRST)) && (c_q.idx <= CNT_W'(UID_LAST));
    assign crc32_en = take && (c_q.idx >= CNT_W'(DATA_START));

    rhc_field_capture #(
        .CNT_W (CNT_W),
        .LEN_W (LEN_W)
    ) u_fields (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (start_i),
        .take_i      (take),
        .idx_i       (c_q.idx),
        .byte_i      (byte_i),
        .uid_o       (uid_o),
        .crc8_ref_o  (crc8_ref),
        .crc32_ref_o (crc32_ref),
        .rev_o       (rev),
        .len_next_o  (len_next)
    );

    rhc_crc_unit #(
        .CRC_W   (8),
        .POLY    (CRC8_POLY),
        .SEED    (CRC8_SEED),
        .REFLECT (1'b0)
    ) u_crc_id (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (start_i),
        .en_i       (crc8_en),
        .data_i     (byte_i),
        .crc_o      (crc8_now),
        .crc_next_o (crc8_next)
    );

    rhc_crc_unit #(
        .CRC_W   (32),
        .POLY    (CRC32C_POLY_R),
        .SEED    (CRC32C_SEED),
        .REFLECT (1'b1)
    ) u_crc_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (start_i),
        .en_i       (crc32_en),
        .data_i     (byte_i),
        .crc_o      (crc32_now),
        .crc_next_o (crc32_next)
    );

    always_comb begin
        c_d = c_q;
        if (start_i) begin
            c_d = '0;
        end else if (take) begin
            c_d.idx = c_q.idx + CNT_W'(1);
            if (c_q.idx == CNT_W'(UID_LAST)) begin
                c_d.uid_match = (crc8_next == crc8_ref);
            end
            if (c_q.idx == CNT_W'(LEN_LAST)) begin
                c_d.size = SIZE_W'(len_next) + SIZE_W'(DATA_START);
                if (c_d.size < SIZE_W'(HDR_BYTES)) begin
                    c_d.phase   = PH_DONE;
                    c_d.valid   = 1'b1;
                    c_d.size_ok = 1'b0;
                    c_d.uid_ok  = c_q.uid_match;
                    c_d.data_ok = 1'b0;
                    c_d.warn    = (rev > REV_MAX_KNOWN);
                end
            end else if ((c_q.idx > CNT_W'(LEN_LAST)) &&
                         (c_q.idx == CNT_W'(c_q.size - SIZE_W'(1)))) begin
                c_d.phase   = PH_DONE;
                c_d.valid   = 1'b1;
                c_d.size_ok = 1'b1;
                c_d.uid_ok  = c_q.uid_match;
                c_d.data_ok = ((~crc32_next) == crc32_ref);
                c_d.warn    = (rev > REV_MAX_KNOWN);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign result_valid_o = c_q.valid;
    assign size_ok_o      = c_q.size_ok;
    assign uid_crc_ok_o   = c_q.uid_ok;
    assign data_crc_ok_o  = c_q.data_ok;
    assign rev_warn_o     = c_q.warn;
    assign image_size_o   = c_q.size;

    // Byte position advances only on offered bytes (R8)
    assert_idx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_valid_i && !start_i) |=> $stable(c_q.idx));

    // A verdict only appears right after a byte was taken (R8)
    assert_verdict_after_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_valid_o) |-> $past(byte_valid_i));

    // Verdict and ID hold until restart (R9)
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid_o && !start_i) |=> (result_valid_o && $stable(uid_o) &&
                                          $stable(data_crc_ok_o) && $stable(uid_crc_ok_o) &&
                                          $stable(image_size_o)));

    // An undersized image never passes the data check (R7)
    assert_small_fails_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid_o && !size_ok_o) |-> !data_crc_ok_o);

    // An accepted size is at least the fixed header (R4)
    assert_size_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid_o && size_ok_o) |-> (image_size_o >= SIZE_W'(HDR_BYTES)));

    // Restart clears the verdict (R10)
    assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!result_valid_o && !rev_warn_o));

    // Warning is only shown with a verdict (R6)
    assert_warn_with_verdict_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rev_warn_o |-> result_valid_o);

endmodule

// File: tb/rom_hdr_checker_test.sv
module rom_hdr_checker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = 8'h00;
    logic        result_valid_o, size_ok_o, uid_crc_ok_o, data_crc_ok_o, rev_warn_o;
    logic [63:0] uid_o;
    logic [16:0] image_size_o;

    int n_total = 0;
    int n_bad   = 0;
    bit reported = 1'b0;

    logic [7:0] img [0:127];

    always #10 clk = ~clk;

    rom_hdr_checker uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .byte_valid_i   (byte_valid_i),
        .byte_i         (byte_i),
        .result_valid_o (result_valid_o),
        .size_ok_o      (size_ok_o),
        .uid_crc_ok_o   (uid_crc_ok_o),
        .data_crc_ok_o  (data_crc_ok_o),
        .rev_warn_o     (rev_warn_o),
        .uid_o          (uid_o),
        .image_size_o   (image_size_o)
    );

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        end
    endtask

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc8(int first, int n);
        logic [7:0] c = 8'hFF;
        for (int i = 0; i < n; i++) begin
            c ^= img[first + i];
            for (int b = 0; b < 8; b++)
                c = c[7] ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
        end
        return c;
    endfunction

    function automatic logic [31:0] ref_crc32c(int first, int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c ^= {24'h0, img[first + i]};
            for (int b = 0; b < 8; b++)
                c = c[0] ? ((c >> 1) ^ 32'h82F63B78) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic build(int len, logic [7:0] rev, logic [63:0] id);
        logic [31:0] c;
        for (int i = 0; i < 128; i++) img[i] = 8'($urandom);
        for (int k = 0; k < 8; k++) img[1 + k] = id[8*k +: 8];
        img[13] = rev;
        img[14] = len[7:0];
        img[15] = len[15:8];
        img[0]  = ref_crc8(1, 8);
        c = ref_crc32c(13, len);
        for (int k = 0; k < 4; k++) img[9 + k] = c[8*k +: 8];
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        byte_valid_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic feed(int n, bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps) begin
                for (int g = 0; g < int'($urandom_range(0, 2)); g++) begin
                    @(negedge clk);
                    byte_valid_i = 1'b0;
                    byte_i = 8'hA5;
                end
            end
            @(negedge clk);
            byte_valid_i = 1'b1;
            byte_i = img[i];
        end
        @(negedge clk);
        byte_valid_i = 1'b0;
    endtask

    task automatic expect_verdict(string tag, int size, bit e_size, bit e_uid,
                                  bit e_data, bit e_warn, logic [63:0] e_id);
        chk({tag, " R8 result_valid"}, result_valid_o, 1);
        chk({tag, " R4 image_size"}, image_size_o, size);
        chk({tag, " R7 size_ok"}, size_ok_o, e_size);
        chk({tag, " R3 uid_crc_ok"}, uid_crc_ok_o, e_uid);
        chk({tag, " R5 data_crc_ok"}, data_crc_ok_o, e_data);
        chk({tag, " R6 rev_warn"}, rev_warn_o, e_warn);
        chk({tag, " R2 uid"}, uid_o, e_id);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        report();
        $finish;
    end

    initial begin
        logic [63:0] id;
        int          len;
        int          kind;
        logic [7:0]  rev;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 result_valid", result_valid_o, 0);
        chk("R1 flags", {size_ok_o, uid_crc_ok_o, data_crc_ok_o, rev_warn_o}, 0);
        chk("R1 uid", uid_o, 0);
        chk("R1 image_size", image_size_o, 0);

        // Minimum legal size, contiguous bytes
        id = 64'h0123_4567_89AB_CDEF;
        build(9, 8'd1, id);
        pulse_start();
        feed(22, 1'b0);
        expect_verdict("min22", 22, 1, 1, 1, 0, id);

        // R8: one byte short gives no verdict
        build(20, 8'd0, id);
        pulse_start();
        feed(32, 1'b1);
        chk("R8 no early verdict", result_valid_o, 0);
        feed(0, 1'b0);
        @(negedge clk);
        byte_valid_i = 1'b1;
        byte_i = img[32];
        @(negedge clk);
        byte_valid_i = 1'b0;
        expect_verdict("len20 gapped", 33, 1, 1, 1, 0, id);

        // R9: extra bytes after the verdict are ignored
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            byte_valid_i = 1'b1;
            byte_i = 8'($urandom);
        end
        @(negedge clk);
        byte_valid_i = 1'b0;
        expect_verdict("R9 after extra bytes", 33, 1, 1, 1, 0, id);

        // R3: ID checksum byte corrupted
        id = {$urandom, $urandom};
        build(30, 8'd0, id);
        img[0] ^= 8'h01;
        pulse_start();
        feed(43, 1'b1);
        expect_verdict("R3 bad id crc", 43, 1, 0, 1, 0, id);

        // R5: one payload byte corrupted
        id = {$urandom, $urandom};
        build(30, 8'd1, id);
        img[25] ^= 8'h10;
        pulse_start();
        feed(43, 1'b1);
        expect_verdict("R5 bad payload", 43, 1, 1, 0, 0, id);

        // R5: stored data checksum corrupted
        build(12, 8'd0, id);
        img[12] ^= 8'h80;
        pulse_start();
        feed(25, 1'b0);
        expect_verdict("R5 bad stored crc", 25, 1, 1, 0, 0, id);

        // R6: unknown revision warns only
        build(40, 8'd7, id);
        pulse_start();
        feed(53, 1'b1);
        expect_verdict("R6 rev 7", 53, 1, 1, 1, 1, id);

        // R7: one below the header size, verdict after byte 15
        build(8, 8'd0, id);
        pulse_start();
        feed(16, 1'b0);
        expect_verdict("R7 size21", 21, 0, 1, 0, 0, id);

        // R7: zero length with bad ID checksum and warning
        build(0, 8'd2, id);
        img[0] ^= 8'hFF;
        pulse_start();
        feed(16, 1'b1);
        expect_verdict("R7 size13", 13, 0, 0, 0, 1, id);

        // R10: restart mid-image, then a byte sent together with start
        build(15, 8'd0, 64'hFEDC_BA98_7654_3210);
        pulse_start();
        feed(10, 1'b0);
        chk("R10 partial no verdict", result_valid_o, 0);
        @(negedge clk);
        start_i = 1'b1;
        byte_valid_i = 1'b1;
        byte_i = 8'h5A;
        @(negedge clk);
        start_i = 1'b0;
        byte_valid_i = 1'b0;
        chk("R10 cleared uid", uid_o, 0);
        chk("R10 cleared verdict", result_valid_o, 0);
        feed(28, 1'b1);
        expect_verdict("R10 restart", 28, 1, 1, 1, 0, 64'hFEDC_BA98_7654_3210);

        // Random images
        for (int t = 0; t < 12; t++) begin
            id   = {$urandom, $urandom};
            len  = int'($urandom_range(9, 100));
            rev  = 8'($urandom_range(0, 3));
            kind = int'($urandom_range(0, 2));
            build(len, rev, id);
            if (kind == 1) img[0] ^= 8'(1 << $urandom_range(0, 7));
            if (kind == 2) img[16 + int'($urandom_range(0, len - 4))] ^= 8'h04;
            pulse_start();
            feed(len + 13, t[0]);
            expect_verdict("random", len + 13, 1, kind != 1, kind != 2, rev > 1, id);
        end

        report();
        $finish;
    end

endmodule